// File: doc/BRIEF.md
# Stack Frame Sequencer for Calls, Interrupts and Returns

This block owns the 16-bit stack pointer of a small 8-bit processor and performs, one byte per clock, the memory writes and reads that save and restore the program counter, the status byte and register pairs on a stack that grows toward lower addresses. The core issues one request code with the current PC, status byte and register-pair value. The block then runs the matching sequence of byte accesses on its memory port and raises a one-cycle done pulse when the sequence is complete. It hands back the restored PC or pair and the restored status byte.

Two pieces of interrupt bookkeeping live here as well. A flag marks that a non-maskable interrupt is being serviced, and only a return from interrupt clears it. An inhibit output tells the interrupt controller not to accept an interrupt before the instruction that follows a status restore, a status load or an interrupt disable has completed. Instruction fetch and interrupt arbitration are left to the surrounding core.

Top module: `stack_seq`

## Requirements
- R1: After reset sp_out equals SP_RESET (default 16'hFF00), and busy, done, mem_we, mem_re, nmi_active and int_inhibit are all low.
- R2: A call (req_op 0) writes the high byte of pc_in+3 at SP-1 and then its low byte at SP-2; a table call (req_op 1) does the same with pc_in+1. Afterwards SP is SP-2.
- R3: An interrupt entry (req_op 2, or req_op 3 for a non-maskable one) writes psw_in at SP-1, the high byte of pc_in at SP-2 and the low byte at SP-3, and leaves SP-3. Code 3 raises nmi_active from the cycle after acceptance; code 2 does not change it.
- R4: A return (req_op 4) reads the low byte from SP and the high byte from SP+1, presents them on ret_word, and leaves SP+2.
- R5: A return from interrupt (req_op 5) reads the PC low byte at SP, the PC high byte at SP+1 and the status byte at SP+2, presents them on ret_word and psw_out, leaves SP+3 and clears nmi_active.
- R6: A pair push (req_op 6) writes the high byte of pair_in at SP-1 and the low byte at SP-2 and leaves SP-2. A status push (req_op 8) writes psw_in at SP-1 and leaves SP-1. A pair pop (req_op 7) reads the low byte at SP and the high byte at SP+1 into ret_word and leaves SP+2. A status pop (req_op 9) reads SP into psw_out and leaves SP+1.
- R7: Each byte access takes exactly one cycle, with mem_we or mem_re high but never both. busy is high for the access cycles only. done pulses for one cycle in the cycle after the last access, so a sequence of N accesses accepted at one edge shows done N+1 cycles later. SP does not move during a sequence.
- R8: A request made while busy is high is ignored, and so are the undefined codes 12 to 15: they cause no access, no done pulse and no change to SP.
- R9: A stack pointer load (req_op 10) copies pair_in into SP with no memory access and shows done in the next cycle. sp_out always shows the current SP.
- R10: int_inhibit rises together with done for a return from interrupt, a status pop or a guard request (req_op 11, issued for a status load or an interrupt disable). It falls on an insn_step pulse, or with the done of any other request.
- R11: nmi_active is not cleared by a return (req_op 4) or by any request other than the return from interrupt.
- R12: All stack address and SP arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 4 | Request code (see requirements) |
| pc_in | input | 16 | PC of the current instruction, or the return PC for interrupt entry |
| psw_in | input | 8 | Status byte to save |
| pair_in | input | 16 | Register pair to push or to load into SP |
| insn_step | input | 1 | Pulse when the core retires an instruction not handled here |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_re |
| mem_addr | output | 16 | Byte address of the current access |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| sp_out | output | 16 | Current stack pointer |
| ret_word | output | 16 | PC restored by a return, or the popped pair |
| psw_out | output | 8 | Restored status byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A sequence is in progress |
| nmi_active | output | 1 | A non-maskable interrupt is being serviced |
| int_inhibit | output | 1 | Hold off interrupt acceptance for one instruction |

## Verification
The bench goes after the byte order inside each frame: a design with the high and low bytes swapped, or with the status byte placed at the bottom of the interrupt frame rather than the top, would return a byte-swapped PC or the wrong status on the way back. It runs every sequence at stack pointers of 0000 and 0001, so a design that lost the 16-bit wrap would write below the stack or restore the wrong value. It checks that a plain return leaves the non-maskable flag set and that the inhibit survives until the next retired instruction, because a design that cleared either too early would let a nested interrupt in. It also issues requests while busy and with undefined codes, which a design with sloppy acceptance would start as extra sequences.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] SP_RESET = 16'hFF00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [3:0]      req_op,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   psw_in,
  input  logic [2*DW-1:0] pair_in,
  input  logic            insn_step,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [2*DW-1:0] sp_out,
  output logic [2*DW-1:0] ret_word,
  output logic [DW-1:0]   psw_out,
  output logic            done,
  output logic            busy,
  output logic            nmi_active,
  output logic            int_inhibit
);
  localparam int AW = 2 * DW;
  localparam logic [3:0] OP_CALL = 4'd0, OP_CALLT = 4'd1, OP_INT = 4'd2, OP_NMI = 4'd3,
                         OP_RET = 4'd4, OP_RETI = 4'd5, OP_PUSHW = 4'd6, OP_POPW = 4'd7,
                         OP_PUSHF = 4'd8, OP_POPF = 4'd9, OP_SPLD = 4'd10, OP_GUARD = 4'd11;

  logic [AW-1:0] sp_q;
  logic [3:0]    op_q;
  logic [1:0]    step_q, len_q;
  logic          wr_q;
  logic [DW-1:0] fr_q [4];

  logic [1:0]    n_len;
  logic          n_wr, n_ok;
  logic [AW-1:0] call_pc;
  logic [DW-1:0] nf [4];
  logic          accept, last;

  always_comb begin
    n_len = 2'd0;
    n_wr = 1'b0;
    n_ok = 1'b1;
    call_pc = pc_in + ((req_op == OP_CALL) ? AW'(3) : AW'(1));
    for (int i = 0; i < 4; i++) nf[i] = '0;
    case (req_op)
      OP_CALL, OP_CALLT: begin
        n_len = 2'd2; n_wr = 1'b1;
        nf[0] = call_pc[AW-1:DW]; nf[1] = call_pc[DW-1:0];
      end
      OP_INT, OP_NMI: begin
        n_len = 2'd3; n_wr = 1'b1;
        nf[0] = psw_in; nf[1] = pc_in[AW-1:DW]; nf[2] = pc_in[DW-1:0];
      end
      OP_PUSHW: begin
        n_len = 2'd2; n_wr = 1'b1;
        nf[0] = pair_in[AW-1:DW]; nf[1] = pair_in[DW-1:0];
      end
      OP_PUSHF: begin
        n_len = 2'd1; n_wr = 1'b1; nf[0] = psw_in;
      end
      OP_RET, OP_POPW: n_len = 2'd2;
      OP_RETI:         n_len = 2'd3;
      OP_POPF:         n_len = 2'd1;
      OP_SPLD, OP_GUARD: n_len = 2'd0;
      default: n_ok = 1'b0;
    endcase
  end

  assign accept = req_valid && !busy && n_ok;
  assign last   = busy && (step_q == len_q - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= SP_RESET;
      op_q <= '0;
      step_q <= '0;
      len_q <= '0;
      wr_q <= 1'b0;
      for (int i = 0; i < 4; i++) fr_q[i] <= '0;
      ret_word <= '0;
      psw_out <= '0;
      done <= 1'b0;
      busy <= 1'b0;
      nmi_active <= 1'b0;
      int_inhibit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q <= req_op;
        len_q <= n_len;
        wr_q <= n_wr;
        step_q <= '0;
        for (int i = 0; i < 4; i++) fr_q[i] <= nf[i];
        if (req_op == OP_NMI) nmi_active <= 1'b1;
        if (n_len == 2'd0) begin
          done <= 1'b1;
          int_inhibit <= (req_op == OP_GUARD);
          if (req_op == OP_SPLD) sp_q <= pair_in;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        step_q <= step_q + 2'd1;
        if (!wr_q) begin
          if (op_q == OP_POPF) psw_out <= mem_rdata;
          else if (step_q == 2'd0) ret_word[DW-1:0] <= mem_rdata;
          else if (step_q == 2'd1) ret_word[AW-1:DW] <= mem_rdata;
          else psw_out <= mem_rdata;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          sp_q <= wr_q ? sp_q - AW'(len_q) : sp_q + AW'(len_q);
          int_inhibit <= (op_q == OP_RETI) || (op_q == OP_POPF);
          if (op_q == OP_RETI) nmi_active <= 1'b0;
        end
      end else if (insn_step) begin
        int_inhibit <= 1'b0;
      end
    end
  end

  assign mem_we    = busy && wr_q;
  assign mem_re    = busy && !wr_q;
  assign mem_addr  = wr_q ? sp_q - AW'(step_q) - AW'(1) : sp_q + AW'(step_q);
  assign mem_wdata = fr_q[step_q];
  assign sp_out    = sp_q;

  p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_sp_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sp_out));
  p_wr_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));
  p_rd_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)));
  p_nmi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_active) |-> (done && op_q == OP_RETI));
  p_inhibit_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_inhibit) |-> done);
endmodule

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, insn_step;
  logic [3:0] req_op;
  logic [15:0] pc_in, pair_in;
  logic [7:0] psw_in, mem_rdata;
  logic [15:0] mem_addr, sp_out, ret_word;
  logic [7:0] mem_wdata, psw_out;
  logic mem_we, mem_re, done, busy, nmi_active, int_inhibit;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .pc_in(pc_in),
    .psw_in(psw_in), .pair_in(pair_in), .insn_step(insn_step), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .sp_out(sp_out), .ret_word(ret_word), .psw_out(psw_out), .done(done), .busy(busy),
    .nmi_active(nmi_active), .int_inhibit(int_inhibit));

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];

  int n_acc;
  bit lw [8];
  logic [15:0] la [8];
  logic [7:0] ld [8];
  int tests = 0, fails = 0;

  always @(negedge clk) begin
    if (mem_we || mem_re) begin
      if (n_acc < 8) begin
        lw[n_acc] = mem_we;
        la[n_acc] = mem_addr;
        ld[n_acc] = mem_we ? mem_wdata : mem_rdata;
      end
      n_acc = n_acc + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] pc, input logic [7:0] psw,
                        input logic [15:0] pair, output int lat);
    @(negedge clk);
    n_acc = 0;
    req_valid = 1'b1; req_op = op; pc_in = pc; psw_in = psw; pair_in = pair;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat < 20, "R7", "sequence finished", lat, 0);
  endtask

  task automatic step_pulse();
    @(negedge clk); insn_step = 1'b1;
    @(negedge clk); insn_step = 1'b0;
  endtask

  task automatic chk_acc(input string req, input int k, input bit w, input logic [15:0] a,
                         input logic [7:0] d);
    chk(lw[k] == w, req, "access direction", lw[k], w);
    chk(la[k] == a, req, "access address", la[k], a);
    chk(ld[k] == d, req, "access data", ld[k], d);
  endtask

  localparam logic [15:0] SPS [4] = '{16'hFE00, 16'h0001, 16'h0000, 16'h8000};

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not end, actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] sp, pc, e, pr;
    logic [7:0] ps;
    n_acc = 0;
    rst_n = 1'b0; req_valid = 1'b0; insn_step = 1'b0; req_op = '0;
    pc_in = '0; psw_in = '0; pair_in = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(sp_out == 16'hFF00, "R1", "reset sp", sp_out, 16'hFF00);
    chk(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
    chk(!mem_we && !mem_re, "R1", "reset strobes", {mem_we, mem_re}, 0);
    chk(!nmi_active && !int_inhibit, "R1", "reset flags", {nmi_active, int_inhibit}, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      sp = SPS[s];
      pc = sp ^ (16'hA55A + 16'(s * 313));
      ps = 8'(8'h3C + s * 37);
      pr = ~pc + 16'h0101;

      run_op(4'd10, 16'h0, 8'h0, sp, lat);
      chk(lat == 1, "R9", "load latency", lat, 1);
      chk(n_acc == 0, "R9", "load accesses", n_acc, 0);
      chk(sp_out == sp, "R9", "loaded sp", sp_out, sp);

      run_op(4'd0, pc, ps, 16'h0, lat);
      e = pc + 16'd3;
      chk(lat == 3, "R7", "call latency", lat, 3);
      chk(n_acc == 2, "R2", "call accesses", n_acc, 2);
      chk_acc("R2", 0, 1'b1, sp - 16'd1, e[15:8]);
      chk_acc("R2", 1, 1'b1, sp - 16'd2, e[7:0]);
      chk(sp_out == sp - 16'd2, "R12", "call sp", sp_out, sp - 16'd2);

      run_op(4'd4, 16'h0, 8'h0, 16'h0, lat);
      chk(lat == 3, "R7", "return latency", lat, 3);
      chk_acc("R4", 0, 1'b0, sp - 16'd2, e[7:0]);
      chk_acc("R4", 1, 1'b0, sp - 16'd1, e[15:8]);
      chk(ret_word == e, "R4", "returned pc", ret_word, e);
      chk(sp_out == sp, "R4", "return sp", sp_out, sp);

      run_op(4'd1, pc, ps, 16'h0, lat);
      e = pc + 16'd1;
      chk_acc("R2", 0, 1'b1, sp - 16'd1, e[15:8]);
      chk_acc("R2", 1, 1'b1, sp - 16'd2, e[7:0]);
      run_op(4'd4, 16'h0, 8'h0, 16'h0, lat);
      chk(ret_word == e, "R2", "table call return pc", ret_word, e);

      run_op(4'd2, pc, ps, 16'h0, lat);
      chk(lat == 4, "R7", "interrupt latency", lat, 4);
      chk(n_acc == 3, "R3", "interrupt accesses", n_acc, 3);
      chk_acc("R3", 0, 1'b1, sp - 16'd1, ps);
      chk_acc("R3", 1, 1'b1, sp - 16'd2, pc[15:8]);
      chk_acc("R3", 2, 1'b1, sp - 16'd3, pc[7:0]);
      chk(sp_out == sp - 16'd3, "R3", "interrupt sp", sp_out, sp - 16'd3);
      chk(!nmi_active, "R3", "maskable entry leaves nmi flag", nmi_active, 0);

      run_op(4'd5, 16'h0, 8'h0, 16'h0, lat);
      chk(lat == 4, "R7", "reti latency", lat, 4);
      chk_acc("R5", 0, 1'b0, sp - 16'd3, pc[7:0]);
      chk_acc("R5", 2, 1'b0, sp - 16'd1, ps);
      chk(ret_word == pc, "R5", "reti pc", ret_word, pc);
      chk(psw_out == ps, "R5", "reti psw", psw_out, ps);
      chk(sp_out == sp, "R5", "reti sp", sp_out, sp);
      chk(int_inhibit, "R10", "inhibit after reti", int_inhibit, 1);
      step_pulse();
      chk(!int_inhibit, "R10", "inhibit cleared by step", int_inhibit, 0);

      run_op(4'd6, 16'h0, 8'h0, pr, lat);
      chk_acc("R6", 0, 1'b1, sp - 16'd1, pr[15:8]);
      chk_acc("R6", 1, 1'b1, sp - 16'd2, pr[7:0]);
      run_op(4'd8, 16'h0, ~ps, 16'h0, lat);
      chk(lat == 2, "R7", "psw push latency", lat, 2);
      chk_acc("R6", 0, 1'b1, sp - 16'd3, ~ps);
      chk(sp_out == sp - 16'd3, "R6", "sp after pushes", sp_out, sp - 16'd3);
      run_op(4'd9, 16'h0, 8'h0, 16'h0, lat);
      chk(psw_out == ~ps, "R6", "popped psw", psw_out, ~ps);
      chk(sp_out == sp - 16'd2, "R6", "sp after psw pop", sp_out, sp - 16'd2);
      chk(int_inhibit, "R10", "inhibit after psw pop", int_inhibit, 1);
      run_op(4'd7, 16'h0, 8'h0, 16'h0, lat);
      chk_acc("R6", 0, 1'b0, sp - 16'd2, pr[7:0]);
      chk(ret_word == pr, "R6", "popped pair", ret_word, pr);
      chk(sp_out == sp, "R6", "sp after pair pop", sp_out, sp);
      chk(!int_inhibit, "R10", "inhibit cleared by next op", int_inhibit, 0);
    end

    sp = 16'hFE00; pc = 16'h1234; ps = 8'h81;
    run_op(4'd10, 16'h0, 8'h0, sp, lat);
    run_op(4'd3, pc, ps, 16'h0, lat);
    chk(nmi_active, "R3", "nmi flag set", nmi_active, 1);
    run_op(4'd0, 16'h4000, 8'h0, 16'h0, lat);
    run_op(4'd4, 16'h0, 8'h0, 16'h0, lat);
    chk(nmi_active, "R11", "return keeps nmi flag", nmi_active, 1);
    chk(ret_word == 16'h4003, "R4", "nested return pc", ret_word, 16'h4003);
    run_op(4'd5, 16'h0, 8'h0, 16'h0, lat);
    chk(!nmi_active, "R5", "reti clears nmi flag", nmi_active, 0);
    chk(ret_word == pc && psw_out == ps, "R5", "nmi frame", ret_word, pc);

    run_op(4'd11, 16'h0, 8'h0, 16'h0, lat);
    chk(lat == 1 && n_acc == 0, "R10", "guard latency", lat, 1);
    chk(int_inhibit, "R10", "guard sets inhibit", int_inhibit, 1);
    chk(sp_out == sp, "R10", "guard keeps sp", sp_out, sp);
    run_op(4'd0, 16'h0200, 8'h0, 16'h0, lat);
    chk(!int_inhibit, "R10", "call clears inhibit", int_inhibit, 0);
    run_op(4'd4, 16'h0, 8'h0, 16'h0, lat);

    begin
      int dn;
      @(negedge clk);
      n_acc = 0;
      req_valid = 1'b1; req_op = 4'd0; pc_in = 16'h0300;
      @(negedge clk);
      req_op = 4'd8; psw_in = 8'h55;
      dn = 0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 6; i++) begin
        if (done) dn++;
        @(negedge clk);
      end
      chk(dn == 1, "R8", "done pulses with request while busy", dn, 1);
      chk(n_acc == 2, "R8", "accesses with request while busy", n_acc, 2);
      chk(sp_out == sp - 16'd2, "R8", "sp with request while busy", sp_out, sp - 16'd2);
      run_op(4'd4, 16'h0, 8'h0, 16'h0, lat);
      chk(ret_word == 16'h0303, "R8", "frame intact", ret_word, 16'h0303);

      for (int c = 12; c < 16; c++) begin
        @(negedge clk);
        n_acc = 0;
        req_valid = 1'b1; req_op = 4'(c); pair_in = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        dn = 0;
        for (int i = 0; i < 4; i++) begin
          if (done || busy) dn++;
          @(negedge clk);
        end
        chk(dn == 0 && n_acc == 0, "R8", "undefined code activity", dn + n_acc, 0);
        chk(sp_out == sp, "R8", "undefined code sp", sp_out, sp);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule